// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps one interrupt request flag and one interrupt mask for each of three timers (A, B and C) in a small 4-bit controller. A one-cycle overflow pulse from a timer sets that timer's flag. The flag then stays set until software clears it. Taking the interrupt does not clear it. Each mask bit holds back its own timer. The block raises one combined timer interrupt toward the CPU when at least one timer has its flag set and its mask clear, and only while the global interrupt enable is high.

Software reaches the six state bits one bit at a time. It supplies a nibble address and a 2-bit bit index, reads the addressed bit back combinationally, and changes it with a set strobe or a clear strobe. Flags accept only clears from software. Masks accept both sets and clears. Reset puts the block in its initial state, with all flags at 0 and all masks at 1. A clock edge seen while stop mode is asserted puts it in the same state. A build parameter can remove timer A entirely.

Top module: `tmr_irq_unit`

## Requirements
- R1: A one-cycle pulse on `ovf_i[i]` (bit 0 = A, 1 = B, 2 = C) sets that timer's flag at the next rising clock edge.
- R2: A set strobe aimed at a flag bit leaves the flag unchanged. Software cannot raise a flag.
- R3: A flag falls only through a clear strobe aimed at its own bit, or through stop or reset. A flag that drives `irq_o` high stays set for as long as software leaves it alone.
- R4: After reset, and after any clock edge with `stop_i` high, every flag is 0 and every mask is 1.
- R5: A set strobe on a mask bit makes the mask 1. A clear strobe on a mask bit makes it 0.
- R6: `pend_o[i]` is 1 exactly when flag i is 1 and mask i is 0. `irq_o` is 1 exactly when `gie_i` is 1 and some `pend_o` bit is 1.
- R7: Bit map (address:bit): A flag 1:2, A mask 1:3, B flag 2:0, B mask 2:1, C flag 2:2, C mask 2:3.
- R8: `rd_bit_o` returns the addressed bit combinationally. Every address other than 1 and 2 reads 0, as do bits 0 and 1 of address 1. Strobes aimed at any of these positions change nothing.
- R9: If an overflow and a clear strobe reach the same flag in the same cycle, the flag ends at 1.
- R10: If the set and clear strobes are both high in the same cycle, no bit changes.
- R11: With `HAS_TIMER_A` = 0, the timer A flag and mask both read 0 and ignore strobes and overflows, and `pend_o[0]` stays 0.
- R12: Stop mode wins over an overflow that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop mode; forces the reset state at each clock edge while high |
| ovf_i | input | 3 | Per-timer overflow pulses (0 = A, 1 = B, 2 = C) |
| gie_i | input | 1 | Global interrupt enable |
| acc_addr_i | input | 4 | Nibble address of the bit access |
| acc_bit_i | input | 2 | Bit index within the nibble |
| bit_set_i | input | 1 | Set strobe for the addressed bit |
| bit_clr_i | input | 1 | Clear strobe for the addressed bit |
| rd_bit_o | output | 1 | Value of the addressed bit |
| pend_o | output | 3 | Per-timer pending (flag and not mask) |
| irq_o | output | 1 | Combined timer interrupt request |

## Verification
The gating path is exercised with flag, mask and enable stepped through separately. A flag that is set while its timer stays masked must not raise `irq_o`. An unmasked flag must show in `pend_o` but must not raise `irq_o` while the enable is low. These cases show that the three conditions are ANDed and not ORed. The same-cycle collisions tell the priorities apart: overflow against clear, set strobe against clear strobe, and stop against overflow. Strobes aimed at unmapped addresses and at timer A's unused bits confirm that the decoder matches both the address and the bit index. A second instance built without timer A shows the removed bits reading 0 while the other timers keep working.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NUM_TMR = 3;
  localparam int ADDR_W  = 4;
  localparam int BIT_W   = 2;

  // Nibble address that holds timer idx's flag and mask
  function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
    return (idx == 0) ? ADDR_W'(1) : ADDR_W'(2);
  endfunction

  // Bit position of timer idx's flag; its mask sits one position above
  function automatic logic [BIT_W-1:0] slot_flag_bit(input int idx);
    return (idx == 1) ? BIT_W'(0) : BIT_W'(2);
  endfunction

  function automatic logic [BIT_W-1:0] slot_mask_bit(input int idx);
    return slot_flag_bit(idx) + BIT_W'(1);
  endfunction

  function automatic logic [NUM_TMR-1:0] pend_calc(input logic [NUM_TMR-1:0] flg,
                                                   input logic [NUM_TMR-1:0] msk);
    return flg & ~msk;
  endfunction
endpackage

// File: rtl/tmr_irq_decode.sv
module tmr_irq_decode import tmr_irq_pkg::*; (
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [BIT_W-1:0]   acc_bit_i,
  input  logic               bit_set_i,
  input  logic               bit_clr_i,
  output logic [NUM_TMR-1:0] flag_clr_o,
  output logic [NUM_TMR-1:0] mask_set_o,
  output logic [NUM_TMR-1:0] mask_clr_o
);
  // Conflicting strobes cancel each other
  logic set_ok;
  logic clr_ok;
  assign set_ok = bit_set_i & ~bit_clr_i;
  assign clr_ok = bit_clr_i & ~bit_set_i;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_hit
    logic at_flag;
    logic at_mask;
    assign at_flag = (acc_addr_i == slot_addr(i)) && (acc_bit_i == slot_flag_bit(i));
    assign at_mask = (acc_addr_i == slot_addr(i)) && (acc_bit_i == slot_mask_bit(i));
    assign flag_clr_o[i] = at_flag & clr_ok;
    assign mask_set_o[i] = at_mask & set_ok;
    assign mask_clr_o[i] = at_mask & clr_ok;
  end
endmodule

// File: rtl/tmr_irq_slot.sv
module tmr_irq_slot #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic ovf_i,
  input  logic flag_clr_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  output logic flag_o,
  output logic mask_o
);
  if (PRESENT) begin : g_live
    logic flag_q;
    logic mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        mask_q <= 1'b1;
      end else if (stop_i) begin
        flag_q <= 1'b0;
        mask_q <= 1'b1;
      end else begin
        if (ovf_i)           flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
        if (mask_set_i)      mask_q <= 1'b1;
        else if (mask_clr_i) mask_q <= 1'b0;
      end
    end
    assign flag_o = flag_q;
    assign mask_o = mask_q;
  end else begin : g_absent
    logic unused_slot;
    assign unused_slot = ^{clk, rst_n, stop_i, ovf_i, flag_clr_i, mask_set_i, mask_clr_i};
    assign flag_o = 1'b0;
    assign mask_o = 1'b0;
  end
endmodule

// File: rtl/tmr_irq_combine.sv
module tmr_irq_combine import tmr_irq_pkg::*; (
  input  logic [NUM_TMR-1:0] flag_i,
  input  logic [NUM_TMR-1:0] mask_i,
  input  logic               gie_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [BIT_W-1:0]   acc_bit_i,
  output logic               rd_bit_o,
  output logic [NUM_TMR-1:0] pend_o,
  output logic               irq_o
);
  assign pend_o = pend_calc(flag_i, mask_i);
  assign irq_o  = gie_i & (|pend_o);

  always_comb begin
    rd_bit_o = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (acc_addr_i == slot_addr(i)) begin
        if (acc_bit_i == slot_flag_bit(i)) rd_bit_o = flag_i[i];
        if (acc_bit_i == slot_mask_bit(i)) rd_bit_o = mask_i[i];
      end
    end
  end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit import tmr_irq_pkg::*; #(
  parameter bit HAS_TIMER_A = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_i,
  input  logic [NUM_TMR-1:0] ovf_i,
  input  logic               gie_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [BIT_W-1:0]   acc_bit_i,
  input  logic               bit_set_i,
  input  logic               bit_clr_i,
  output logic               rd_bit_o,
  output logic [NUM_TMR-1:0] pend_o,
  output logic               irq_o
);
  // Named internal events, visible to the bound checker
  logic [NUM_TMR-1:0] flag_clr_hit;
  logic [NUM_TMR-1:0] mask_set_hit;
  logic [NUM_TMR-1:0] mask_clr_hit;
  logic [NUM_TMR-1:0] flag_q;
  logic [NUM_TMR-1:0] mask_q;

  tmr_irq_decode u_dec (
    .acc_addr_i (acc_addr_i),
    .acc_bit_i  (acc_bit_i),
    .bit_set_i  (bit_set_i),
    .bit_clr_i  (bit_clr_i),
    .flag_clr_o (flag_clr_hit),
    .mask_set_o (mask_set_hit),
    .mask_clr_o (mask_clr_hit)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_slot
    tmr_irq_slot #(.PRESENT((i == 0) ? HAS_TIMER_A : 1'b1)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_i     (stop_i),
      .ovf_i      (ovf_i[i]),
      .flag_clr_i (flag_clr_hit[i]),
      .mask_set_i (mask_set_hit[i]),
      .mask_clr_i (mask_clr_hit[i]),
      .flag_o     (flag_q[i]),
      .mask_o     (mask_q[i])
    );
  end

  tmr_irq_combine u_comb (
    .flag_i     (flag_q),
    .mask_i     (mask_q),
    .gie_i      (gie_i),
    .acc_addr_i (acc_addr_i),
    .acc_bit_i  (acc_bit_i),
    .rd_bit_o   (rd_bit_o),
    .pend_o     (pend_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/tmr_irq_unit_chk.sv
module tmr_irq_unit_chk import tmr_irq_pkg::*; #(
  parameter bit HAS_TIMER_A = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop_i,
  input logic [NUM_TMR-1:0] ovf_i,
  input logic               gie_i,
  input logic [ADDR_W-1:0]  acc_addr_i,
  input logic               bit_clr_i,
  input logic               rd_bit_o,
  input logic [NUM_TMR-1:0] pend_o,
  input logic               irq_o,
  input logic [NUM_TMR-1:0] flag_q,
  input logic [NUM_TMR-1:0] mask_q
);
  localparam logic [NUM_TMR-1:0] PRES = {{(NUM_TMR-1){1'b1}}, HAS_TIMER_A};

  // R1, R9: an overflow outside stop sets the flag at the next edge
  a_r1_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ovf_i & PRES)) && !stop_i) |=> ((flag_q & $past(ovf_i & PRES)) == $past(ovf_i & PRES)));

  // R2: a flag never rises without an overflow
  a_r2_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) != '0) |-> ($past(ovf_i) != '0));

  // R3: a flag falls only by a clear strobe or stop
  a_r3_fall_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q) != '0) |-> ($past(bit_clr_i) || $past(stop_i)));

  // R4, R12: stop forces the initial state
  a_r4_stop_state: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (flag_q == '0 && mask_q == PRES));

  // R6: request needs the enable and a pending timer
  a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie_i && pend_o != '0));

  a_r6_irq_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && pend_o != '0) |-> irq_o);

  a_r6_masked_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & mask_q) == '0);

  // R8: unmapped addresses read 0
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr_i != ADDR_W'(1) && acc_addr_i != ADDR_W'(2)) |-> !rd_bit_o);

  // R11: a removed timer A never pends
  a_r11_no_timer_a: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_TIMER_A |-> !pend_o[0]);
endmodule

bind tmr_irq_unit tmr_irq_unit_chk #(.HAS_TIMER_A(HAS_TIMER_A)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_i     (stop_i),
  .ovf_i      (ovf_i),
  .gie_i      (gie_i),
  .acc_addr_i (acc_addr_i),
  .bit_clr_i  (bit_clr_i),
  .rd_bit_o   (rd_bit_o),
  .pend_o     (pend_o),
  .irq_o      (irq_o),
  .flag_q     (flag_q),
  .mask_q     (mask_q)
);

// File: tb/tmr_irq_unit_test.sv
module tmr_irq_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_i = 1'b0;
  logic [2:0] ovf_i = '0;
  logic       gie_i = 1'b0;
  logic [3:0] acc_addr_i = '0;
  logic [1:0] acc_bit_i = '0;
  logic       bit_set_i = 1'b0;
  logic       bit_clr_i = 1'b0;
  logic       rd_bit_o, irq_o, rd_noa, irq_noa;
  logic [2:0] pend_o, pend_noa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .ovf_i(ovf_i), .gie_i(gie_i),
    .acc_addr_i(acc_addr_i), .acc_bit_i(acc_bit_i), .bit_set_i(bit_set_i),
    .bit_clr_i(bit_clr_i), .rd_bit_o(rd_bit_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  tmr_irq_unit #(.HAS_TIMER_A(1'b0)) uut_noa (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .ovf_i(ovf_i), .gie_i(gie_i),
    .acc_addr_i(acc_addr_i), .acc_bit_i(acc_bit_i), .bit_set_i(bit_set_i),
    .bit_clr_i(bit_clr_i), .rd_bit_o(rd_noa), .pend_o(pend_noa), .irq_o(irq_noa)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, input int b, output logic v, output logic vn);
    acc_addr_i = 4'(a);
    acc_bit_i  = 2'(b);
    #1;
    v  = rd_bit_o;
    vn = rd_noa;
  endtask

  task automatic strobe(input int a, input int b, input bit s, input bit c);
    @(negedge clk);
    acc_addr_i = 4'(a); acc_bit_i = 2'(b); bit_set_i = s; bit_clr_i = c;
    @(negedge clk);
    bit_set_i = 1'b0; bit_clr_i = 1'b0;
    #1;
  endtask

  task automatic pulse_ovf(input logic [2:0] v);
    @(negedge clk); ovf_i = v;
    @(negedge clk); ovf_i = '0;
    #1;
  endtask

  task automatic t_reset();
    logic v, vn;
    rd(1, 3, v, vn); check("R4", "A mask after reset", v, 1);
    rd(2, 1, v, vn); check("R4", "B mask after reset", v, 1);
    rd(2, 3, v, vn); check("R4", "C mask after reset", v, 1);
    rd(2, 0, v, vn); check("R4", "B flag after reset", v, 0);
    check("R4", "irq after reset", irq_o, 0);
  endtask

  task automatic t_overflow_masked();
    logic v, vn;
    pulse_ovf(3'b010);
    rd(2, 0, v, vn); check("R1", "B flag after overflow", v, 1);
    check("R6", "pend while masked", pend_o, 0);
  endtask

  task automatic t_gating();
    logic v, vn;
    strobe(2, 1, 1'b0, 1'b1);
    rd(2, 1, v, vn); check("R5", "B mask cleared", v, 0);
    gie_i = 1'b0; #1;
    check("R6", "pend unmasked", pend_o, 3'b010);
    check("R6", "irq with gie low", irq_o, 0);
    gie_i = 1'b1; #1;
    check("R6", "irq with gie high", irq_o, 1);
    repeat (5) @(negedge clk);
    #1;
    rd(2, 0, v, vn); check("R3", "B flag held while requesting", v, 1);
    strobe(2, 0, 1'b0, 1'b1);
    rd(2, 0, v, vn); check("R3", "B flag cleared by strobe", v, 0);
    check("R6", "irq after clear", irq_o, 0);
    gie_i = 1'b0;
  endtask

  task automatic t_flag_set_ignored();
    logic v, vn;
    strobe(2, 2, 1'b1, 1'b0);
    rd(2, 2, v, vn); check("R2", "C flag after set strobe", v, 0);
    strobe(2, 1, 1'b1, 1'b0);
    rd(2, 1, v, vn); check("R5", "B mask set", v, 1);
  endtask

  task automatic t_unmapped();
    logic v, vn;
    pulse_ovf(3'b001);
    strobe(3, 2, 1'b0, 1'b1);
    strobe(0, 2, 1'b0, 1'b1);
    strobe(1, 0, 1'b0, 1'b1);
    rd(1, 2, v, vn); check("R8", "A flag after stray clears", v, 1);
    check("R7", "A flag at 1:2", v, 1);
    rd(3, 2, v, vn); check("R8", "addr 3 reads 0", v, 0);
    rd(1, 0, v, vn); check("R8", "addr 1 bit 0 reads 0", v, 0);
    strobe(0, 3, 1'b0, 1'b1);
    rd(1, 3, v, vn); check("R8", "A mask after stray clear", v, 1);
  endtask

  task automatic t_ovf_vs_clr();
    logic v, vn;
    strobe(1, 2, 1'b0, 1'b1);
    rd(1, 2, v, vn); check("R3", "A flag cleared", v, 0);
    @(negedge clk);
    acc_addr_i = 4'd1; acc_bit_i = 2'd2; bit_clr_i = 1'b1; ovf_i = 3'b001;
    @(negedge clk);
    bit_clr_i = 1'b0; ovf_i = '0; #1;
    rd(1, 2, v, vn); check("R9", "A flag overflow beats clear", v, 1);
  endtask

  task automatic t_both_strobes();
    logic v, vn;
    strobe(1, 3, 1'b1, 1'b1);
    rd(1, 3, v, vn); check("R10", "A mask with both strobes", v, 1);
    strobe(1, 2, 1'b1, 1'b1);
    rd(1, 2, v, vn); check("R10", "A flag with both strobes", v, 1);
  endtask

  task automatic t_stop();
    logic v, vn;
    pulse_ovf(3'b111);
    strobe(2, 3, 1'b0, 1'b1);
    @(negedge clk);
    stop_i = 1'b1; ovf_i = 3'b100;
    @(negedge clk);
    stop_i = 1'b0; ovf_i = '0; #1;
    rd(2, 2, v, vn); check("R12", "C flag stop beats overflow", v, 0);
    rd(1, 2, v, vn); check("R4", "A flag after stop", v, 0);
    rd(2, 3, v, vn); check("R4", "C mask after stop", v, 1);
  endtask

  task automatic t_no_timer_a();
    logic v, vn;
    strobe(1, 3, 1'b0, 1'b1);
    pulse_ovf(3'b011);
    gie_i = 1'b1;
    rd(1, 2, v, vn); check("R11", "no-A flag reads 0", vn, 0);
    strobe(1, 3, 1'b1, 1'b0);
    rd(1, 3, v, vn); check("R11", "no-A mask reads 0", vn, 0);
    check("R11", "no-A pend A", pend_noa[0], 0);
    check("R11", "no-A irq", irq_noa, 0);
    rd(2, 0, v, vn); check("R11", "no-A B flag works", vn, 1);
    gie_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_overflow_masked();
    t_gating();
    t_flag_set_ignored();
    t_unmapped();
    t_ovf_vs_clr();
    t_both_strobes();
    t_stop();
    t_no_timer_a();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule